// File: doc/BRIEF.md
# Eight-Bit Bidirectional Pin Bank with Override Multiplexing

This block is a general-purpose I/O bank of eight pins, managed through three
registers on a small internal register bus. Each pin has a direction bit and an
output latch bit. A pin whose direction bit is clear drives its latch bit onto
the pad. A pin whose direction bit is set is left undriven and only sampled. A
two-flop synchronizer cleans up pad levels before software reads them through
the pin-level register. The latch register reads back what was stored, not what
is on the pad.

Two sources can take a pin away from the registers. A peripheral can claim a
pin and force both its direction and its value. An external-memory bus enable
hands every pin except bit 5 to the memory-control function. Neither source
writes the stored direction bits. Software can therefore read-modify-write the
direction register safely while a pin is claimed.

Each pin is in one of three ownership states: `OWN_REG` (registers drive it),
`OWN_PERIPH` (peripheral override) and `OWN_XBUS` (external-memory function).
Ownership is recomputed every cycle from the inputs, with no hysteresis. The
transitions are:
- `OWN_REG`→`OWN_PERIPH` when the pin's override enable rises.
- any state→`OWN_XBUS` when the bus enable rises (not for bit 5).
- `OWN_XBUS`→`OWN_PERIPH` or `OWN_REG` when the bus enable falls, depending on the pin's override enable.
- `OWN_PERIPH`→`OWN_REG` when the pin's override enable falls.

Top module: `pinbank_io`

## Requirements
- R1: After reset the direction register reads 0xFF, the latch register reads 0x00 and `pad_oe` is 0x00, so every pin is an input.
- R2: A write to address 0 (pin level) or address 1 (latch) stores `reg_wdata` in the output latch at that clock edge. A read of address 1 returns the stored latch. With no write to those addresses the latch holds.
- R3: A write to address 2 stores `reg_wdata` in the direction register. A read of address 2 returns it. Otherwise the direction register holds.
- R4: For a pin owned by the registers, `pad_oe` is the inverse of its direction bit (direction bit 1 = input, `pad_oe` 0) and `pad_out` is its latch bit.
- R5: A read of address 0 returns `pad_in` as it was two clock edges earlier.
- R6: A pin with `ovr_en` set and not taken by the bus has `pad_oe = ~ovr_dir` and `pad_out = ovr_out`. The direction register read value is unaffected by any override.
- R7: While `xbus_en` is 1, every pin except bit 5 takes `pad_oe = xbus_oe` and `pad_out = xbus_out`, above any peripheral override.
- R8: Bit 5 ignores `xbus_en` and follows the peripheral override or the registers.
- R9: A read of address 3 returns 0x00. A write to address 3 changes neither the latch nor the direction register.
- R10: Writing 0xCF to the direction register with no overrides gives `pad_oe` = 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 pin level, 1 latch, 2 direction |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| ovr_en | input | 8 | Per-pin peripheral claim |
| ovr_dir | input | 8 | Forced direction while claimed (1 = input) |
| ovr_out | input | 8 | Forced output value while claimed |
| xbus_en | input | 1 | External-memory function enable |
| xbus_oe | input | 8 | Output enables from the memory-control function |
| xbus_out | input | 8 | Output values from the memory-control function |
| pad_in | input | 8 | Level seen at the pads |
| pad_out | output | 8 | Value presented to the pad drivers |
| pad_oe | output | 8 | Pad driver enable (1 = drive) |

## Verification
The hardest situation to reach from the ports combines three things on one pin:
a peripheral claim, the bus enable, and software rewriting the direction
register. The stored direction must survive untouched, and bit 5 must drop out
of bus ownership. A pseudo-random sequence draws the claim, bus enable and bus
values afresh each round and writes a new direction value in the same round.
After each round the pad outputs are compared with the priority rule and the
direction register is read back. Separate full sweeps cover all 256 values of
the direction and latch registers and of the pad input.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_LEVEL = 2'd0,
        RA_LATCH = 2'd1,
        RA_DIR   = 2'd2,
        RA_NONE  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        OWN_REG    = 2'd0,
        OWN_PERIPH = 2'd1,
        OWN_XBUS   = 2'd2
    } pin_owner_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

    // cycles since reset, saturating, for the delay check below
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    if (STAGES == 2) begin : g_chk2
        AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3) |-> (dout == $past(din, 2))); // R5
    end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [W-1:0]          wdata,
    input  logic [W-1:0]          level,
    output logic [W-1:0]          rdata,
    output logic [W-1:0]          lat_q,
    output logic [W-1:0]          dir_q
);

    reg_addr_e sel;
    logic      hit_lat;
    logic      hit_dir;

    assign sel     = reg_addr_e'(addr);
    assign hit_lat = wr_en && (sel == RA_LEVEL || sel == RA_LATCH);
    assign hit_dir = wr_en && (sel == RA_DIR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (hit_lat) begin
            lat_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (hit_dir) begin
            dir_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            RA_LEVEL: rdata = level;
            RA_LATCH: rdata = lat_q;
            RA_DIR:   rdata = dir_q;
            default:  rdata = '0;
        endcase
    end

    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == 2'd0 || addr == 2'd1)) |=> $stable(lat_q)); // R2
    AST_LAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> (lat_q == $past(wdata))); // R2
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd2) |=> $stable(dir_q)); // R3

endmodule

// File: rtl/pinbank_mux.sv
module pinbank_mux
    import pinbank_pkg::*;
#(
    parameter int W        = 8,
    parameter int FREE_BIT = 5
) (
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ovr_en,
    input  logic [W-1:0] ovr_dir,
    input  logic [W-1:0] ovr_out,
    input  logic         bus_en,
    input  logic [W-1:0] bus_oe,
    input  logic [W-1:0] bus_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);

    localparam logic [W-1:0] BUS_MASK = ~(W'(1) << FREE_BIT);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_owner_e owner;

        always_comb begin
            if (bus_en && BUS_MASK[i]) begin
                owner = OWN_XBUS;
            end else if (ovr_en[i]) begin
                owner = OWN_PERIPH;
            end else begin
                owner = OWN_REG;
            end
        end

        always_comb begin
            unique case (owner)
                OWN_XBUS: begin
                    pin_oe[i]  = bus_oe[i];
                    pin_out[i] = bus_out[i];
                end
                OWN_PERIPH: begin
                    pin_oe[i]  = ~ovr_dir[i];
                    pin_out[i] = ovr_out[i];
                end
                default: begin
                    pin_oe[i]  = ~dir_q[i];
                    pin_out[i] = lat_q[i];
                end
            endcase
        end
    end

endmodule

// File: rtl/pinbank_io.sv
module pinbank_io
    import pinbank_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int FREE_BIT    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic [PORT_W-1:0]     reg_wdata,
    output logic [PORT_W-1:0]     reg_rdata,
    input  logic [PORT_W-1:0]     ovr_en,
    input  logic [PORT_W-1:0]     ovr_dir,
    input  logic [PORT_W-1:0]     ovr_out,
    input  logic                  xbus_en,
    input  logic [PORT_W-1:0]     xbus_oe,
    input  logic [PORT_W-1:0]     xbus_out,
    input  logic [PORT_W-1:0]     pad_in,
    output logic [PORT_W-1:0]     pad_out,
    output logic [PORT_W-1:0]     pad_oe
);

    localparam logic [PORT_W-1:0] BUS_PINS = ~(PORT_W'(1) << FREE_BIT);

    logic [PORT_W-1:0] level_s;
    logic [PORT_W-1:0] lat_q;
    logic [PORT_W-1:0] dir_q;

    pinbank_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (level_s)
    );

    pinbank_regs #(.W(PORT_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(reg_wr),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .level(level_s),
        .rdata(reg_rdata),
        .lat_q(lat_q),
        .dir_q(dir_q)
    );

    pinbank_mux #(.W(PORT_W), .FREE_BIT(FREE_BIT)) u_mux (
        .lat_q  (lat_q),
        .dir_q  (dir_q),
        .ovr_en (ovr_en),
        .ovr_dir(ovr_dir),
        .ovr_out(ovr_out),
        .bus_en (xbus_en),
        .bus_oe (xbus_oe),
        .bus_out(xbus_out),
        .pin_oe (pad_oe),
        .pin_out(pad_out)
    );

    AST_REG_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        (!xbus_en && ovr_en == '0) |-> (pad_oe == ~dir_q && pad_out == lat_q)); // R4
    AST_PERIPH_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        !xbus_en |-> (((pad_oe ^ ~ovr_dir) & ovr_en) == '0)); // R6
    AST_BUS_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_en |-> ((((pad_oe ^ xbus_oe) | (pad_out ^ xbus_out)) & BUS_PINS) == '0)); // R7
    AST_FREE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_en && !ovr_en[FREE_BIT]) |-> (pad_oe[FREE_BIT] == ~dir_q[FREE_BIT])); // R8

endmodule

// File: tb/pinbank_io_test.sv
module pinbank_io_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] ovr_en = '0, ovr_dir = '0, ovr_out = '0;
    logic       xbus_en = 1'b0;
    logic [7:0] xbus_oe = '0, xbus_out = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_lat = 8'h00;
    logic [7:0] m_dir = 8'hFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_io uut (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ovr_en(ovr_en), .ovr_dir(ovr_dir), .ovr_out(ovr_out),
        .xbus_en(xbus_en), .xbus_oe(xbus_oe), .xbus_out(xbus_out),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0 || a == 2'd1) m_lat = d;
        if (a == 2'd2) m_dir = d;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [15:0] expect_pads();
        logic [7:0] eo, ev;
        for (int i = 0; i < 8; i++) begin
            if (xbus_en && i != 5) begin
                eo[i] = xbus_oe[i]; ev[i] = xbus_out[i];
            end else if (ovr_en[i]) begin
                eo[i] = ~ovr_dir[i]; ev[i] = ovr_out[i];
            end else begin
                eo[i] = ~m_dir[i]; ev[i] = m_lat[i];
            end
        end
        return {eo, ev};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [15:0] lfsr = 16'hACE1;
        logic [15:0] ex;

        repeat (3) @(negedge clk);
        read_reg(2'd2, rd); check8("R1 dir in reset", rd, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(2'd2, rd); check8("R1 dir after reset", rd, 8'hFF);
        read_reg(2'd1, rd); check8("R1 latch after reset", rd, 8'h00);
        check8("R1 pad_oe after reset", pad_oe, 8'h00);

        // R10: the documented mixed direction value
        write_reg(2'd2, 8'hCF);
        #1;
        check8("R10 pad_oe for 0xCF", pad_oe, 8'h30);

        // R3 / R4: full sweep of direction values
        for (int v = 0; v < 256; v++) begin
            write_reg(2'd2, 8'(v));
            read_reg(2'd2, rd);
            check8("R3 dir readback", rd, 8'(v));
            check8("R4 pad_oe from dir", pad_oe, ~8'(v));
        end

        // R2 / R4: full sweep of latch values via both addresses
        for (int v = 0; v < 256; v++) begin
            write_reg((v % 2 == 0) ? 2'd0 : 2'd1, 8'(v ^ 8'h5A));
            read_reg(2'd1, rd);
            check8("R2 latch readback", rd, 8'(v ^ 8'h5A));
            check8("R4 pad_out from latch", pad_out, 8'(v ^ 8'h5A));
        end

        // R9: unmapped address
        read_reg(2'd3, rd); check8("R9 unmapped read", rd, 8'h00);
        write_reg(2'd3, 8'hA5);
        m_lat = 8'hA5 ^ 8'hFF ^ 8'hFF; // placeholder not used
        m_lat = 8'(255 ^ 8'h5A);
        read_reg(2'd1, rd); check8("R9 latch untouched", rd, m_lat);
        read_reg(2'd2, rd); check8("R9 dir untouched", rd, 8'hFF);

        // R5: pad sampling delay, full sweep
        @(negedge clk);
        pad_in = 8'h00;
        @(negedge clk); @(negedge clk); @(negedge clk);
        for (int v = 1; v < 256; v++) begin
            logic [7:0] prev;
            prev = 8'(v - 1);
            pad_in = 8'(v);
            @(negedge clk);
            read_reg(2'd0, rd); check8("R5 level after one edge", rd, prev);
            @(negedge clk);
            read_reg(2'd0, rd); check8("R5 level after two edges", rd, 8'(v));
        end

        // R6 / R7 / R8: random ownership mixes with direction rewrites
        for (int k = 0; k < 400; k++) begin
            logic [7:0] nd;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            nd = lfsr[7:0];
            @(negedge clk);
            ovr_en  = lfsr[15:8] ^ 8'(k);
            ovr_dir = lfsr[7:0];
            ovr_out = lfsr[11:4];
            xbus_en = lfsr[3];
            xbus_oe = lfsr[12:5];
            xbus_out = ~lfsr[9:2];
            write_reg(2'd2, nd);
            #1;
            ex = expect_pads();
            if (xbus_en) begin
                check8("R7 bus pad_oe", pad_oe & 8'hDF, ex[15:8] & 8'hDF);
                check8("R7 bus pad_out", pad_out & 8'hDF, ex[7:0] & 8'hDF);
                check8("R8 free pin oe", {7'd0, pad_oe[5]}, {7'd0, ex[13]});
                check8("R8 free pin out", {7'd0, pad_out[5]}, {7'd0, ex[5]});
            end else begin
                check8("R6 override pad_oe", pad_oe, ex[15:8]);
                check8("R6 override pad_out", pad_out, ex[7:0]);
            end
            read_reg(2'd2, rd);
            check8("R6 dir unaffected by overrides", rd, nd);
        end

        // R8: bus enabled, no overrides, bit 5 follows registers
        @(negedge clk);
        ovr_en = '0; xbus_en = 1'b1; xbus_oe = 8'hFF; xbus_out = 8'hFF;
        write_reg(2'd1, 8'h00);
        write_reg(2'd2, 8'hDF);
        #1;
        check8("R8 bit5 driven low from regs", {pad_oe[5], pad_out[5]}, 8'b10);
        check8("R7 other pins from bus", pad_oe & 8'hDF, 8'hDF);

        finish_run();
    end

endmodule